// File: doc/BRIEF.md
# Selectable-Source Interrupt Latch

This block is the interrupt controller of a data-acquisition front end. A control word chooses one acquisition event as the interrupt source through an encoded 3-bit field: pacer tick, external interrupt, FIFO not empty, FIFO half full or end of scan. A master enable bit arms the controller. When the chosen event shows a rising edge while the controller is armed, a latch is set. The latch drives a single interrupt request line, and the request line is gated by the enable bit.

Software reads the control fields back together with two read-only flags. One flag gives the latch state in inverted sense, so it reads 0 while an interrupt is pending. The other is a sticky sample-FIFO overflow indication. A separate clear strobe drops the pending interrupt. A FIFO reset clears the overflow indication.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `status` reads 16'h0010: enable and select are 0, the overflow flag is 0, and the latch-state bit is 1 (no interrupt pending).
- R2: A cycle with `cfg_we`=1 loads `cfg_wdata[15]` as the enable and `cfg_wdata[14:12]` as the source select. From the next cycle on, both read back at `status[15]` and `status[14:12]`.
- R3: The select codes are 1 = `ev_in[0]` (pacer), 2 = `ev_in[1]` (external), 3 = `ev_in[2]` (FIFO not empty), 4 = `ev_in[3]` (FIFO half full) and 5 = `ev_in[4]` (end of scan). Take a clock edge at which the enable is 1, the selected input is 1, and that input was 0 at the previous edge. After that edge the latch is set and `status[4]` reads 0.
- R4: Only a rising edge of the selected input sets the latch. An input that stays high does not set the latch again after a clear, and edges on inputs that are not selected have no effect.
- R5: Select codes 0, 6 and 7 never set the latch, whatever the event inputs do.
- R6: While the enable held in the control register is 0, no event sets the latch.
- R7: `irq` is 1 exactly when the latch is set and the enable is 1. Clearing the enable drops `irq` but leaves the latch, and `status[4]`, unchanged.
- R8: A cycle with `latch_clr`=1 and no setting event resets the latch at that clock edge.
- R9: When a setting event and `latch_clr` occur at the same clock edge, the latch ends up set.
- R10: A `fifo_ovf` pulse sets `status[10]`. The bit stays 1 until a cycle with `fifo_rst`=1 clears it.
- R11: When `fifo_rst` and `fifo_ovf` occur at the same clock edge, `status[10]` ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: bit 15 enable, bits 14:12 source select |
| latch_clr | input | 1 | Clear strobe for the pending interrupt |
| ev_in | input | 5 | Event levels: pacer, external, FIFO not empty, FIFO half full, end of scan (bit 0 first) |
| fifo_ovf | input | 1 | Sample FIFO overflow pulse |
| fifo_rst | input | 1 | Sample FIFO reset |
| irq | output | 1 | Interrupt request |
| status | output | 16 | Read word: enable, select, overflow flag (bit 10), latch state (bit 4, 0 = pending) |

## Verification
The hardest cases to reach are those where several effects meet at one clock edge. Examples are a rising edge on the selected source arriving together with the clear strobe, or an overflow pulse arriving together with a FIFO reset. The level-held event that must not re-arm after a clear is a related case. Directed sequences build each of these on purpose. First they hold an event high across a clear, then they place set and clear in the same cycle. A long random phase then changes the enable and select often, using the codes 0, 6 and 7 as well. This catches clear/set and write/event overlaps that the directed cases do not list.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CTRL_W    = 16;
  localparam int EN_BIT    = 15;
  localparam int SEL_LO    = 12;
  localparam int SEL_W     = 3;
  localparam int OVF_BIT   = 10;
  localparam int LSTAT_BIT = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_PACER = 3'd1,
    SRC_EXT   = 3'd2,
    SRC_FNE   = 3'd3,
    SRC_FHF   = 3'd4,
    SRC_EOS   = 3'd5
  } src_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             en_d,
  input  logic [SEL_W-1:0] sel_d,
  output irq_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg.en  <= en_d;
      cfg.sel <= sel_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg)); // R2
endmodule

// File: rtl/irq_edge_pick.sv
module irq_edge_pick #(
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic [NUM_SRC-1:0] ev_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  logic [NUM_SRC-1:0] ev_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] match;

  always_ff @(posedge clk) begin
    ev_q <= ev_in;
  end

  assign rise = ev_in & ~ev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign match[g] = rise[g] & (sel == SEL_W'(g + 1));
  end

  assign hit = |match;

  AST_ONE_MATCH: assert property (@(posedge clk)
    $onehot0(match)); // R3
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hit,
  input  logic clr,
  output logic lat_q
);
  logic set;
  assign set = en & hit;

  always_ff @(posedge clk) begin
    if (rst)       lat_q <= 1'b0;
    else if (set)  lat_q <= 1'b1;
    else if (clr)  lat_q <= 1'b0;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    set |=> lat_q); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !lat_q); // R8
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr && set) |=> lat_q); // R9
endmodule

// File: rtl/irq_ovf_flag.sv
module irq_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic ovf_evt,
  input  logic fifo_rst,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst || fifo_rst) flag_q <= 1'b0;
    else if (ovf_evt)    flag_q <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !fifo_rst) |=> flag_q); // R10
  AST_OVF_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |=> !flag_q); // R11
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CTRL_W-1:0]  cfg_wdata,
  input  logic               latch_clr,
  input  logic [NUM_SRC-1:0] ev_in,
  input  logic               fifo_ovf,
  input  logic               fifo_rst,
  output logic               irq,
  output logic [CTRL_W-1:0]  status
);
  irq_cfg_t cfg;
  logic     hit;
  logic     lat_q;
  logic     ovf_q;
  logic     unused_wdata;

  assign unused_wdata = ^{cfg_wdata[SEL_LO-1:0]};

  irq_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .en_d  (cfg_wdata[EN_BIT]),
    .sel_d (cfg_wdata[SEL_LO +: SEL_W]),
    .cfg   (cfg)
  );

  irq_edge_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
    .clk   (clk),
    .ev_in (ev_in),
    .sel   (cfg.sel),
    .hit   (hit)
  );

  irq_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .en    (cfg.en),
    .hit   (hit),
    .clr   (latch_clr),
    .lat_q (lat_q)
  );

  irq_ovf_flag u_ovf (
    .clk      (clk),
    .rst      (rst),
    .ovf_evt  (fifo_ovf),
    .fifo_rst (fifo_rst),
    .flag_q   (ovf_q)
  );

  assign irq = lat_q & cfg.en;

  always_comb begin
    status            = '0;
    status[EN_BIT]    = cfg.en;
    status[SEL_LO +: SEL_W] = cfg.sel;
    status[OVF_BIT]   = ovf_q;
    status[LSTAT_BIT] = ~lat_q;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!irq && status == 16'h0010)); // R1
  AST_BAD_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!lat_q && (cfg.sel == 3'd0 || int'(cfg.sel) > NUM_SRC)) |=> !lat_q); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!lat_q && !cfg.en) |=> !lat_q); // R6
  AST_EN_DROP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (lat_q && !latch_clr) |=> lat_q); // R7
endmodule

// File: tb/sim_acq_irq_ctrl.sv
`timescale 1ns/1ps
module sim_acq_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        latch_clr;
  logic [4:0]  ev_in;
  logic        fifo_ovf;
  logic        fifo_rst;
  logic        irq;
  logic [15:0] status;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic       m_en, m_lat, m_ovf;
  logic [2:0] m_sel;
  logic [4:0] m_prev;

  always #5 clk = ~clk;

  acq_irq_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .latch_clr(latch_clr), .ev_in(ev_in), .fifo_ovf(fifo_ovf),
    .fifo_rst(fifo_rst), .irq(irq), .status(status)
  );

  function automatic logic [15:0] exp_status();
    return {m_en, m_sel, 1'b0, m_ovf, 5'b0, ~m_lat, 4'b0};
  endfunction

  function automatic logic exp_irq();
    return m_lat & m_en;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_step(input logic r, input logic we, input logic [15:0] wd,
                            input logic clr, input logic [4:0] ev,
                            input logic ovf, input logic fr);
    logic [4:0] rise;
    logic hit, set;
    if (r) begin
      m_en = 0; m_sel = 0; m_lat = 0; m_ovf = 0;
    end else begin
      rise = ev & ~m_prev;
      hit  = (m_sel >= 3'd1 && m_sel <= 3'd5) ? rise[m_sel - 3'd1] : 1'b0;
      set  = m_en & hit;
      m_lat = set ? 1'b1 : (clr ? 1'b0 : m_lat);
      m_ovf = fr ? 1'b0 : (m_ovf | ovf);
      if (we) begin
        m_en  = wd[15];
        m_sel = wd[14:12];
      end
    end
    m_prev = ev;
  endtask

  // Drive at negedge, advance one edge, check at the following negedge.
  task automatic cyc(input logic we, input logic [15:0] wd, input logic clr,
                     input logic [4:0] ev, input logic ovf, input logic fr);
    cfg_we = we; cfg_wdata = wd; latch_clr = clr;
    ev_in = ev; fifo_ovf = ovf; fifo_rst = fr;
    @(posedge clk);
    model_step(rst, we, wd, clr, ev, ovf, fr);
    @(negedge clk);
    chk("R7 irq", {15'b0, irq}, {15'b0, exp_irq()});
    chk("R2 ctrl readback", {status[15:12], 12'b0}, {exp_status() & 16'hF000});
    chk("R3 latch state", {15'b0, status[4]}, {15'b0, exp_status() >> 4} & 16'h1);
    chk("R10 overflow", {15'b0, status[10]}, {15'b0, exp_status() >> 10} & 16'h1);
  endtask

  task automatic idle(input logic [4:0] ev);
    cyc(0, 16'h0, 0, ev, 0, 0);
  endtask

  task automatic wr(input logic en, input logic [2:0] sel);
    cyc(1, {en, sel, 12'h0}, 0, 5'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_sel = 0; m_lat = 0; m_ovf = 0; m_prev = 0;
    rst = 1;
    @(negedge clk);
    cyc(0, 16'h0, 0, 5'b0, 0, 0);
    cyc(0, 16'h0, 0, 5'b0, 0, 0);
    rst = 0;
    idle(5'b0);
    chk("R1 reset status", status, 16'h0010);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);

    wr(1, 3'd1);
    chk("R2 write", status, 16'h9010);
    idle(5'b00001);
    chk("R3 pacer sets", status, 16'h9000);
    chk("R3 irq up", {15'b0, irq}, 16'h1);
    cyc(0, 16'h0, 1, 5'b00001, 0, 0);
    idle(5'b00001);
    idle(5'b00001);
    chk("R4 held level no reset", {15'b0, irq}, 16'h0);
    idle(5'b00010);
    chk("R4 unselected ignored", status, 16'h9010);

    wr(1, 3'd6);
    idle(5'b11111);
    chk("R5 code 6 quiet", {15'b0, status[4]}, 16'h1);
    wr(1, 3'd0);
    idle(5'b11111);
    chk("R5 code 0 quiet", {15'b0, status[4]}, 16'h1);
    wr(1, 3'd7);
    idle(5'b11111);
    chk("R5 code 7 quiet", {15'b0, status[4]}, 16'h1);

    wr(0, 3'd2);
    idle(5'b00010);
    chk("R6 disabled quiet", status, 16'h2010);

    wr(1, 3'd5);
    idle(5'b10000);
    chk("R3 eos sets", status, 16'hD000);
    wr(0, 3'd5);
    chk("R7 irq gated", {15'b0, irq}, 16'h0);
    chk("R7 latch kept", status, 16'h5000);
    wr(1, 3'd4);
    chk("R7 irq returns", {15'b0, irq}, 16'h1);

    cyc(0, 16'h0, 1, 5'b0, 0, 0);
    chk("R8 clear", status, 16'hC010);
    cyc(0, 16'h0, 1, 5'b01000, 0, 0);
    chk("R9 set beats clear", {15'b0, irq}, 16'h1);

    cyc(0, 16'h0, 0, 5'b0, 1, 0);
    idle(5'b0);
    idle(5'b0);
    chk("R10 sticky", {15'b0, status[10]}, 16'h1);
    cyc(0, 16'h0, 0, 5'b0, 0, 1);
    chk("R10 fifo reset clears", {15'b0, status[10]}, 16'h0);
    cyc(0, 16'h0, 0, 5'b0, 1, 0);
    cyc(0, 16'h0, 0, 5'b0, 1, 1);
    chk("R11 reset wins", {15'b0, status[10]}, 16'h0);

    for (int i = 0; i < 4000; i++) begin
      logic we, clr, ovf, fr;
      logic [15:0] wd;
      logic [4:0] ev;
      we  = ($urandom % 12) == 0;
      wd  = 16'($urandom);
      wd[15] = ($urandom % 4) != 0;
      clr = ($urandom % 6) == 0;
      ev  = 5'($urandom) & 5'($urandom);
      ovf = ($urandom % 30) == 0;
      fr  = ($urandom % 25) == 0;
      cyc(we, wd, clr, ev, ovf, fr);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule